// File: doc/BRIEF.md
# Sixteen-Bit ALU with Three-Way Compare Flags

This block is the execute stage of a small register machine. Each cycle it takes an opcode, two operands that the issue logic has already resolved (register value or immediate) and the current flags word. It returns the result, a destination write-enable and the next flags word, all registered, one clock later. Bitwise logic, logical shifts, addition and subtraction are supported. The shift and subtract operations also come in reversed forms that exchange the roles of the two operands. A compare operation writes no register. It rewrites three flag bits (equal, unsigned below and signed less-than) and copies every other flag bit through unchanged.

The issue logic sends opcode zero, or any code outside the table below, in cycles with no work. Such a cycle writes nothing and leaves the flags as they were. The data width, flags width, flag bit positions and the shifter style (log-stage barrel or plain operator) are parameters. Operand fetch, memory access and control flow stay outside the block.

Top module: `alu_cmp_core`

## Requirements
- R1: Opcodes OR=1, AND=2 and XOR=3 return the bitwise OR, AND and XOR of operand-1 and operand-2, with the write-enable high.
- R2: Opcode ADD=8 returns operand-1 plus operand-2, and SUB=9 returns operand-1 minus operand-2, both modulo 2^W, with the write-enable high.
- R3: Opcode SHL=4 returns operand-1 shifted left by operand-2, and SHR=6 returns operand-1 shifted right by operand-2. Both are logical shifts that fill with zeros, with the write-enable high.
- R4: Opcode RSHL=5 returns operand-2 shifted left by operand-1, and RSHR=7 returns operand-2 shifted right by operand-1.
- R5: Opcode RSUB=10 returns operand-2 minus operand-1 modulo 2^W, with the write-enable high.
- R6: In all four shift opcodes, a shift amount (the whole W-bit amount operand) of W or more gives a result of zero.
- R7: Opcode CMP=11 sets flag bit 0 (equal) when the operands are equal and clears it otherwise.
- R8: CMP sets flag bit 1 (below) when operand-1 < operand-2 as unsigned numbers and clears it otherwise.
- R9: CMP sets flag bit 2 (less-than) when operand-1 < operand-2 as two's-complement numbers and clears it otherwise.
- R10: CMP keeps the write-enable low and the result zero. Every flag bit other than bits 0 to 2 equals the corresponding bit of the incoming flags.
- R11: Opcode 0 and opcodes 12 to 63 keep the write-enable low and the result zero, and return the incoming flags unchanged. The ALU opcodes other than CMP also return the incoming flags unchanged.
- R12: All outputs are registered. They reflect the inputs present at the previous rising clock edge. While the asynchronous active-low reset is asserted, the result is zero, the write-enable is low and the flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_code | input | 6 | Operation selector |
| opnd_a | input | W | Operand-1 |
| opnd_b | input | W | Operand-2, register or immediate already chosen |
| flags_in | input | FLW | Current flags word |
| result | output | W | Registered result |
| result_we | output | 1 | Destination register write-enable |
| flags_out | output | FLW | Registered next flags word |

## Verification
The result, the write-enable and the flags each pass through one register. All three are due on the first rising edge after the inputs are presented. The bench drives each operation on a falling edge and compares all three outputs on the next falling edge, half a period after that register has loaded. A new operation is applied at that same falling edge, so every cycle is checked against exactly one stimulus. The reset values are checked while reset is still held, before the first operation is driven.

// File: rtl/alu_cmp_pkg.sv
package alu_cmp_pkg;

   localparam int OPC_W = 6;

   typedef enum logic [OPC_W-1:0] {
      OPC_NONE = 6'd0,
      OPC_OR   = 6'd1,
      OPC_AND  = 6'd2,
      OPC_XOR  = 6'd3,
      OPC_SHL  = 6'd4,
      OPC_RSHL = 6'd5,
      OPC_SHR  = 6'd6,
      OPC_RSHR = 6'd7,
      OPC_ADD  = 6'd8,
      OPC_SUB  = 6'd9,
      OPC_RSUB = 6'd10,
      OPC_CMP  = 6'd11
   } opc_e;

   // Class of an opcode, used to steer the result mux
   typedef enum logic [1:0] {
      CLS_NONE  = 2'd0,
      CLS_LOGAR = 2'd1,
      CLS_SHIFT = 2'd2,
      CLS_CMP   = 2'd3
   } opc_cls_e;

   function automatic opc_cls_e opc_class(input logic [OPC_W-1:0] code);
      opc_cls_e c;
      case (code)
         OPC_OR, OPC_AND, OPC_XOR, OPC_ADD, OPC_SUB, OPC_RSUB: c = CLS_LOGAR;
         OPC_SHL, OPC_RSHL, OPC_SHR, OPC_RSHR:                 c = CLS_SHIFT;
         OPC_CMP:                                              c = CLS_CMP;
         default:                                              c = CLS_NONE;
      endcase
      return c;
   endfunction

   // Reversed opcodes exchange operand roles
   function automatic logic opc_swaps(input logic [OPC_W-1:0] code);
      return (code == OPC_RSHL) || (code == OPC_RSHR) || (code == OPC_RSUB);
   endfunction

endpackage

// File: rtl/alu_logic_arith.sv
module alu_logic_arith
   import alu_cmp_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [OPC_W-1:0] code,
   input  logic [W-1:0]     x,
   input  logic [W-1:0]     y,
   output logic [W-1:0]     out
);

   logic [W-1:0] sum_v;
   logic [W-1:0] diff_v;

   // One adder and one subtractor. A reversed subtract arrives already swapped.
   assign sum_v  = x + y;
   assign diff_v = x - y;

   always_comb begin
      case (code)
         OPC_OR:            out = x | y;
         OPC_AND:           out = x & y;
         OPC_XOR:           out = x ^ y;
         OPC_ADD:           out = sum_v;
         OPC_SUB, OPC_RSUB: out = diff_v;
         default:           out = '0;
      endcase
   end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
   parameter int W      = 16,
   parameter bit BARREL = 1'b1
) (
   input  logic [W-1:0] val,
   input  logic [W-1:0] amt,
   input  logic         go_left,
   output logic [W-1:0] out
);

   localparam int LG = (W > 1) ? $clog2(W) : 1;
   localparam logic [W-1:0] W_AS_AMT = W[W-1:0];

   logic too_far;
   logic [W-1:0] shaped;

   // Amounts of W or more flush every bit out
   assign too_far = (amt >= W_AS_AMT);

   generate
      if (BARREL) begin : g_barrel
         logic [W-1:0] pre;
         logic [W-1:0] stg [0:LG];
         logic [W-1:0] post;

         // Right shifts reuse the left chain through bit reversal
         for (genvar i = 0; i < W; i++) begin : g_rev_in
            assign pre[i] = go_left ? val[i] : val[W-1-i];
         end

         assign stg[0] = pre;
         for (genvar k = 0; k < LG; k++) begin : g_stage
            assign stg[k+1] = amt[k] ? (stg[k] << (1 << k)) : stg[k];
         end

         for (genvar i = 0; i < W; i++) begin : g_rev_out
            assign post[i] = go_left ? stg[LG][i] : stg[LG][W-1-i];
         end

         assign shaped = post;
      end else begin : g_operator
         assign shaped = go_left ? (val << amt) : (val >> amt);
      end
   endgenerate

   assign out = too_far ? '0 : shaped;

endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
   parameter int W = 16
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic         is_eq,
   output logic         is_below,
   output logic         is_less
);

   assign is_eq    = (x == y);
   assign is_below = (x < y);
   assign is_less  = ($signed(x) < $signed(y));

endmodule

// File: rtl/alu_cmp_core.sv
module alu_cmp_core
   import alu_cmp_pkg::*;
#(
   parameter int W       = 16,
   parameter int FLW     = 16,
   parameter int EQ_POS  = 0,
   parameter int BE_POS  = 1,
   parameter int LT_POS  = 2,
   parameter bit BARREL  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [OPC_W-1:0]     op_code,
   input  logic [W-1:0]         opnd_a,
   input  logic [W-1:0]         opnd_b,
   input  logic [FLW-1:0]       flags_in,
   output logic [W-1:0]         result,
   output logic                 result_we,
   output logic [FLW-1:0]       flags_out
);

   localparam logic [FLW-1:0] CMP_MASK =
      (FLW'(1) << EQ_POS) | (FLW'(1) << BE_POS) | (FLW'(1) << LT_POS);

   // Elaboration-time checks on the parameters
   generate
      if (W < 2) begin : g_bad_w
         $error("alu_cmp_core: W must be at least 2");
      end
      if (FLW < 3) begin : g_bad_flw
         $error("alu_cmp_core: FLW must hold three flags");
      end
      if (EQ_POS >= FLW || BE_POS >= FLW || LT_POS >= FLW ||
          EQ_POS < 0 || BE_POS < 0 || LT_POS < 0) begin : g_bad_pos
         $error("alu_cmp_core: flag position outside flags word");
      end
      if (EQ_POS == BE_POS || EQ_POS == LT_POS || BE_POS == LT_POS) begin : g_dup_pos
         $error("alu_cmp_core: flag positions must differ");
      end
   endgenerate

   opc_cls_e     cls;
   logic         swap;
   logic [W-1:0] x_v, y_v;
   logic [W-1:0] la_out, sh_out;
   logic         go_left;
   logic         c_eq, c_be, c_lt;
   logic [W-1:0] res_nx;
   logic         we_nx;
   logic [FLW-1:0] fl_nx;

   assign cls     = opc_class(op_code);
   assign swap    = opc_swaps(op_code);
   assign x_v     = swap ? opnd_b : opnd_a;
   assign y_v     = swap ? opnd_a : opnd_b;
   assign go_left = (op_code == OPC_SHL) || (op_code == OPC_RSHL);

   alu_logic_arith #(.W(W)) u_logar (
      .code (op_code),
      .x    (x_v),
      .y    (y_v),
      .out  (la_out)
   );

   alu_shifter #(.W(W), .BARREL(BARREL)) u_shift (
      .val     (x_v),
      .amt     (y_v),
      .go_left (go_left),
      .out     (sh_out)
   );

   alu_compare #(.W(W)) u_cmp (
      .x        (opnd_a),
      .y        (opnd_b),
      .is_eq    (c_eq),
      .is_below (c_be),
      .is_less  (c_lt)
   );

   always_comb begin
      res_nx = '0;
      we_nx  = 1'b0;
      fl_nx  = flags_in;
      case (cls)
         CLS_LOGAR: begin
            res_nx = la_out;
            we_nx  = 1'b1;
         end
         CLS_SHIFT: begin
            res_nx = sh_out;
            we_nx  = 1'b1;
         end
         CLS_CMP: begin
            fl_nx[EQ_POS] = c_eq;
            fl_nx[BE_POS] = c_be;
            fl_nx[LT_POS] = c_lt;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result    <= '0;
         result_we <= 1'b0;
         flags_out <= '0;
      end else begin
         result    <= res_nx;
         result_we <= we_nx;
         flags_out <= fl_nx;
      end
   end

   // ---------------- assertions ----------------
   logic past_cmp, past_none, past_shift;
   assign past_cmp   = (op_code == OPC_CMP);
   assign past_none  = (cls == CLS_NONE);
   assign past_shift = (cls == CLS_SHIFT);

   // R10: compare writes nothing
   p_cmp_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(past_cmp) |-> !result_we && result == '0);

   // R10: flag bits outside the compare trio pass through
   p_flag_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(past_cmp) |->
         (flags_out & ~CMP_MASK) == ($past(flags_in) & ~CMP_MASK));

   // R7: equal flag follows operand equality
   p_cmp_eq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(past_cmp) |->
         flags_out[EQ_POS] == ($past(opnd_a) == $past(opnd_b)));

   // R8, R9: equality excludes both orderings
   p_eq_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(past_cmp) && flags_out[EQ_POS] |->
         !flags_out[BE_POS] && !flags_out[LT_POS]);

   // R11: idle and unknown opcodes touch nothing
   p_nonalu_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(past_none) |->
         !result_we && flags_out == $past(flags_in));

   // R6: oversize shift amount gives zero
   p_big_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(past_shift) && ($past(y_v) >= W) |-> result == '0);

endmodule

// File: tb/tb_alu_cmp_core.sv
module tb_alu_cmp_core;
   import alu_cmp_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  op_code = '0;
   logic [15:0] opnd_a = '0, opnd_b = '0, flags_in = '0;
   logic [15:0] result, flags_out;
   logic        result_we;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   alu_cmp_core dut (
      .clk(clk), .rst_n(rst_n), .op_code(op_code), .opnd_a(opnd_a),
      .opnd_b(opnd_b), .flags_in(flags_in), .result(result),
      .result_we(result_we), .flags_out(flags_out)
   );

   function automatic logic [15:0] pick(input int i);
      case (i)
         0: return 16'h0000;  1: return 16'h0001;  2: return 16'hFFFF;
         3: return 16'h8000;  4: return 16'h7FFF;  5: return 16'd15;
         6: return 16'd16;    7: return 16'd17;
         default: return 16'((i * 40503 + 12345) % 65536);
      endcase
   endfunction

   function automatic int sgn(input logic [15:0] v);
      return (v >= 16'h8000) ? int'(v) - 65536 : int'(v);
   endfunction

   function automatic int shl(input int v, input int s);
      return (s >= 16) ? 0 : (v * (1 << s)) % 65536;
   endfunction

   function automatic int shr(input int v, input int s);
      return (s >= 16) ? 0 : v / (1 << s);
   endfunction

   function automatic string tag(input int op);
      case (op)
         1, 2, 3:  return "R1";
         8, 9:     return "R2";
         4, 6:     return "R3/R6";
         5, 7:     return "R4/R6";
         10:       return "R5";
         11:       return "R7/R8/R9/R10";
         default:  return "R11";
      endcase
   endfunction

   task automatic run_op(input int op, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] f);
      int ia, ib, er;
      logic ew;
      logic [15:0] ef;
      ia = int'(a); ib = int'(b);
      er = 0; ew = 1'b1; ef = f;
      case (op)
         1:  er = int'(a | b);
         2:  er = int'(a & b);
         3:  er = int'(a ^ b);
         4:  er = shl(ia, ib);
         5:  er = shl(ib, ia);
         6:  er = shr(ia, ib);
         7:  er = shr(ib, ia);
         8:  er = (ia + ib) % 65536;
         9:  er = (ia - ib + 65536) % 65536;
         10: er = (ib - ia + 65536) % 65536;
         11: begin
            ew = 1'b0;
            ef[0] = (ia == ib);
            ef[1] = (ia < ib);
            ef[2] = (sgn(a) < sgn(b));
         end
         default: ew = 1'b0;
      endcase
      op_code = 6'(op); opnd_a = a; opnd_b = b; flags_in = f;
      @(negedge clk);
      checks++;
      if (result !== 16'(er) || result_we !== ew || flags_out !== ef) begin
         errors++;
         $display("FAIL %s op=%0d a=%h b=%h: got res=%h we=%b fl=%h exp res=%h we=%b fl=%h",
                  tag(op), op, a, b, result, result_we, flags_out, 16'(er), ew, ef);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset values
      checks++;
      if (result !== 16'h0 || result_we !== 1'b0 || flags_out !== 16'h0) begin
         errors++;
         $display("FAIL R12 reset: got res=%h we=%b fl=%h exp res=0000 we=0 fl=0000",
                  result, result_we, flags_out);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R1..R5, R7..R10: every ALU opcode over operand pairs, varying flags
      for (int op = 1; op <= 11; op++)
         for (int i = 0; i < 24; i++)
            for (int j = 0; j < 24; j++)
               run_op(op, pick(i), pick(j), pick(i + j + op + 8) ^ 16'h00F0);

      // R6: shift amounts across and past the width, in both operand roles
      for (int s = 0; s < 34; s++)
         for (int v = 0; v < 6; v++) begin
            run_op(4, pick(v + 8), 16'(s), 16'h1234);
            run_op(6, pick(v + 8), 16'(s), 16'h1234);
            run_op(5, 16'(s), pick(v + 8), 16'h4321);
            run_op(7, 16'(s), pick(v + 8), 16'h4321);
         end
      run_op(4, 16'hFFFF, 16'h8000, 16'h0);
      run_op(7, 16'hFFFF, 16'hFFFF, 16'h0);

      // R10: compare keeps outer flag bits, whatever they hold
      run_op(11, 16'h0005, 16'h0005, 16'hFFF8);
      run_op(11, 16'h8000, 16'h0001, 16'hFFFF);
      run_op(11, 16'h0001, 16'h8000, 16'hAAA8);

      // R11: idle and unknown opcodes
      for (int op = 12; op < 64; op++)
         run_op(op, pick(op), pick(op + 3), pick(op + 7));
      run_op(0, 16'hFFFF, 16'h0001, 16'h5A5A);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule